// File: doc/BRIEF.md
# Feature Unlock Write-Sequence Detector

This block watches the byte writes made to the address register of a display controller and keeps one flag that says whether a set of enhanced features is open. It powers up locked. To unlock, software first writes a nonzero byte and then a zero byte, which synchronises the detector. It then writes a fixed fifteen-byte signature. If software writes only the first fourteen signature bytes and then any other byte, the detector locks again.

Writes that are not aimed at the watched register have no effect. Each qualifying write moves the detector by exactly one step. A byte that breaks a partial match is not thrown away: if it is nonzero, it counts as the first half of a new synchronising pair. A debug view shows the search phase and how many signature bytes have matched so far. What the flag gates elsewhere is the concern of the blocks that read it.

Top module: `ulk_top`

## Requirements
- R1: While reset is asserted and after it is released, `unlocked` is 0, `dbg_phase` is 0 and `dbg_count` is 0.
- R2: A cycle with `wr_en` low, or with `wr_sel` low, changes none of `unlocked`, `dbg_phase` or `dbg_count`.
- R3: `dbg_phase` encodes the sync search. 0 means hunting for a nonzero byte. 1 means a nonzero byte was seen and a zero byte is awaited. 2 means signature matching. In phase 0 a nonzero write moves to phase 1 and a zero write stays in phase 0. In phase 1 a zero write moves to phase 2 with count 0 and a nonzero write stays in phase 1.
- R4: In phase 2, `dbg_count` is the number of signature bytes matched so far. Each write equal to the next expected byte raises it by one. The signature, in order, is FF 77 B3 51 A8 D4 62 39 9C 46 2B 15 8A CD EE.
- R5: The write that supplies the fifteenth byte (EE) after fourteen matches sets `unlocked` to 1 at that clock edge. The detector then returns to phase 0 with count 0.
- R6: After fourteen matches, a write of any byte other than EE clears `unlocked` at that clock edge. That write is then treated as a new sync start: a nonzero byte goes to phase 1 and a zero byte goes to phase 0.
- R7: A mismatch before the fourteenth match leaves `unlocked` unchanged and clears `dbg_count`. A nonzero mismatching byte goes to phase 1 and a zero byte goes to phase 0.
- R8: Completing the full signature while already unlocked keeps `unlocked` at 1. Completing the truncated signature while already locked keeps it at 0.
- R9: Every output updates on the rising clock edge of the qualifying write, one register stage after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle high |
| wr_sel | input | 1 | High when the write targets the display-controller address register |
| wr_data | input | DATA_W | Written byte |
| unlocked | output | 1 | 1 when the enhanced features are open |
| dbg_phase | output | 2 | Search phase (0 hunt, 1 armed, 2 signature) |
| dbg_count | output | CNT_W | Signature bytes matched so far |

## Verification
The assertions assume that `wr_data` is stable and known whenever `wr_en` and `wr_sel` are both high. They also assume that reset is held for at least one clock edge before any write. The stimulus changes inputs only on falling edges and holds each write for exactly one rising edge. It asserts the strobe only after reset has been released. It drops the strobe after the last write, so the outputs never see a partial or undefined byte.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

  typedef enum logic [1:0] {
    PH_HUNT  = 2'd0,
    PH_ARMED = 2'd1,
    PH_SIG   = 2'd2
  } phase_t;

  // Expected signature byte at a given match position.
  function automatic logic [7:0] sig_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:    b = 8'hFF;
      4'd1:    b = 8'h77;
      4'd2:    b = 8'hB3;
      4'd3:    b = 8'h51;
      4'd4:    b = 8'hA8;
      4'd5:    b = 8'hD4;
      4'd6:    b = 8'h62;
      4'd7:    b = 8'h39;
      4'd8:    b = 8'h9C;
      4'd9:    b = 8'h46;
      4'd10:   b = 8'h2B;
      4'd11:   b = 8'h15;
      4'd12:   b = 8'h8A;
      4'd13:   b = 8'hCD;
      4'd14:   b = 8'hEE;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ulk_wr_qual.sv
module ulk_wr_qual #(
  parameter int DATA_W = 8
) (
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              byte_ev,
  output logic              byte_zero
);
  // A byte event is a strobe aimed at the watched register.
  assign byte_ev   = wr_en & wr_sel;
  assign byte_zero = (wr_data == '0);
endmodule

// File: rtl/ulk_seq_fsm.sv
module ulk_seq_fsm
  import ulk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SIG_LEN = 15,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_ev,
  input  logic              byte_zero,
  input  logic [DATA_W-1:0] byte_val,
  output phase_t            phase,
  output logic [CNT_W-1:0]  count,
  output logic              full_hit,
  output logic              trunc_hit
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_LEN - 1);

  phase_t            nxt_phase;
  logic [CNT_W-1:0]  nxt_count;
  logic              match;
  phase_t            restart_phase;

  assign match         = (byte_val == DATA_W'(sig_byte(4'(count))));
  assign restart_phase = byte_zero ? PH_HUNT : PH_ARMED;

  always_comb begin
    nxt_phase = phase;
    nxt_count = count;
    full_hit  = 1'b0;
    trunc_hit = 1'b0;
    if (byte_ev) begin
      case (phase)
        PH_HUNT: begin
          if (!byte_zero) nxt_phase = PH_ARMED;
        end
        PH_ARMED: begin
          if (byte_zero) begin
            nxt_phase = PH_SIG;
            nxt_count = '0;
          end
        end
        PH_SIG: begin
          if (count == LAST) begin
            nxt_count = '0;
            if (match) begin
              full_hit  = 1'b1;
              nxt_phase = PH_HUNT;
            end else begin
              trunc_hit = 1'b1;
              nxt_phase = restart_phase;
            end
          end else if (match) begin
            nxt_count = count + 1'b1;
          end else begin
            nxt_count = '0;
            nxt_phase = restart_phase;
          end
        end
        default: begin
          nxt_phase = PH_HUNT;
          nxt_count = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_HUNT;
      count <= '0;
    end else begin
      phase <= nxt_phase;
      count <= nxt_count;
    end
  end
endmodule

// File: rtl/ulk_lock_reg.sv
module ulk_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic full_hit,
  input  logic trunc_hit,
  output logic unlocked
);
  always_ff @(posedge clk) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (full_hit)  unlocked <= 1'b1;
    else if (trunc_hit) unlocked <= 1'b0;
  end
endmodule

// File: rtl/ulk_top.sv
module ulk_top
  import ulk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SIG_LEN = 15,
  parameter int CNT_W   = $clog2(SIG_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              unlocked,
  output logic [1:0]        dbg_phase,
  output logic [CNT_W-1:0]  dbg_count
);
  // Named internal events, visible to the bound checker.
  logic   byte_ev;
  logic   byte_zero;
  logic   full_hit;
  logic   trunc_hit;
  phase_t phase;

  ulk_wr_qual #(.DATA_W(DATA_W)) u_qual (
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .byte_ev   (byte_ev),
    .byte_zero (byte_zero)
  );

  ulk_seq_fsm #(.DATA_W(DATA_W), .SIG_LEN(SIG_LEN), .CNT_W(CNT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_ev   (byte_ev),
    .byte_zero (byte_zero),
    .byte_val  (wr_data),
    .phase     (phase),
    .count     (dbg_count),
    .full_hit  (full_hit),
    .trunc_hit (trunc_hit)
  );

  ulk_lock_reg u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_hit  (full_hit),
    .trunc_hit (trunc_hit),
    .unlocked  (unlocked)
  );

  assign dbg_phase = phase;
endmodule

// File: rtl/ulk_chk.sv
module ulk_chk
  import ulk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SIG_LEN = 15,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_ev,
  input logic              full_hit,
  input logic              trunc_hit,
  input logic [DATA_W-1:0] wr_data,
  input logic              unlocked,
  input logic [1:0]        dbg_phase,
  input logic [CNT_W-1:0]  dbg_count
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_LEN - 1);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ev |=> ($stable(unlocked) && $stable(dbg_phase) && $stable(dbg_count)));

  p_sync_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && dbg_phase == 2'd1 && wr_data == '0)
      |=> (dbg_phase == 2'd2 && dbg_count == '0));

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ev && dbg_phase == 2'd2 && dbg_count < LAST &&
     wr_data == DATA_W'(sig_byte(4'(dbg_count))))
      |=> (dbg_count == CNT_W'($past(dbg_count) + 1'b1)));

  p_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> (unlocked && dbg_phase == 2'd0));

  p_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_hit |=> !unlocked);

  p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(full_hit));

  p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlocked) |-> $past(trunc_hit));

  p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_phase != 2'd3) && (dbg_phase == 2'd2 || dbg_count == '0));
endmodule

bind ulk_top ulk_chk #(.DATA_W(DATA_W), .SIG_LEN(SIG_LEN), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_ev   (byte_ev),
  .full_hit  (full_hit),
  .trunc_hit (trunc_hit),
  .wr_data   (wr_data),
  .unlocked  (unlocked),
  .dbg_phase (dbg_phase),
  .dbg_count (dbg_count)
);

// File: tb/tb_ulk_top.sv
module tb_ulk_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       unlocked;
  logic [1:0] dbg_phase;
  logic [3:0] dbg_count;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic       unl;
    logic [1:0] ph;
    logic [3:0] cnt;
    string      req;
  } exp_t;

  exp_t q[$];

  // Bench-side copy of the signature, written independently.
  logic [7:0] key [15] = '{8'hFF, 8'h77, 8'hB3, 8'h51, 8'hA8, 8'hD4, 8'h62,
                           8'h39, 8'h9C, 8'h46, 8'h2B, 8'h15, 8'h8A, 8'hCD, 8'hEE};

  logic cur_unl = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ulk_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .unlocked  (unlocked),
    .dbg_phase (dbg_phase),
    .dbg_count (dbg_count)
  );

  task automatic check_now(input exp_t e);
    n_cmp++;
    if (unlocked !== e.unl || dbg_phase !== e.ph || dbg_count !== e.cnt) begin
      n_bad++;
      $display("FAIL %s: got unl=%0b ph=%0d cnt=%0d, expected unl=%0b ph=%0d cnt=%0d",
               e.req, unlocked, dbg_phase, dbg_count, e.unl, e.ph, e.cnt);
    end
  endtask

  // Monitor: compares one expected item per falling edge after a write.
  always @(negedge clk) begin
    if (q.size() > 0) check_now(q.pop_front());
  end

  // Driver: one cycle with the given strobe, then push the expectation.
  task automatic drive(input logic en, input logic sel, input logic [7:0] d,
                       input logic e_unl, input logic [1:0] e_ph,
                       input logic [3:0] e_cnt, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d;
    @(posedge clk);
    e.unl = e_unl; e.ph = e_ph; e.cnt = e_cnt; e.req = req;
    q.push_back(e);
    cur_unl = e_unl;
  endtask

  task automatic sync_pair(input logic [7:0] nz);
    drive(1, 1, nz,    cur_unl, 2'd1, 4'd0, "R3 nonzero arms");
    drive(1, 1, 8'h00, cur_unl, 2'd2, 4'd0, "R3 zero enters signature");
  endtask

  // Write the first n signature bytes, starting with the phase at signature, count 0.
  task automatic sig_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      if (i == 14) drive(1, 1, key[i], 1'b1, 2'd0, 4'd0, "R5 final byte unlocks");
      else         drive(1, 1, key[i], cur_unl, 2'd2, 4'(i + 1), "R4 count steps");
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.unl = 0; r.ph = 0; r.cnt = 0; r.req = "R1 reset state";
    check_now(r);
    rst_n = 1'b1;
    @(negedge clk);
    check_now(r);

    // Hunt: zero stays, nonzero arms, repeated nonzero stays armed.
    drive(1, 1, 8'h00, 0, 2'd0, 4'd0, "R3 zero in hunt stays");
    drive(1, 1, 8'h42, 0, 2'd1, 4'd0, "R3 nonzero arms");
    drive(1, 1, 8'h13, 0, 2'd1, 4'd0, "R3 nonzero stays armed");
    // Ignored writes while armed.
    drive(1, 0, 8'h00, 0, 2'd1, 4'd0, "R2 other register ignored");
    drive(0, 1, 8'h00, 0, 2'd1, 4'd0, "R2 no strobe ignored");
    drive(1, 1, 8'h00, 0, 2'd2, 4'd0, "R3 zero enters signature");

    // Full unlock with ignored writes in the middle (R9 timing via monitor).
    sig_bytes(5);
    drive(1, 0, 8'hD4, 0, 2'd2, 4'd5, "R2 other register mid-signature");
    drive(0, 1, 8'hD4, 0, 2'd2, 4'd5, "R2 no strobe mid-signature");
    for (int i = 5; i < 15; i++) begin
      if (i == 14) drive(1, 1, key[i], 1'b1, 2'd0, 4'd0, "R5 final byte unlocks R9");
      else         drive(1, 1, key[i], 1'b0, 2'd2, 4'(i + 1), "R4 count steps");
    end

    // Unlock again while unlocked.
    sync_pair(8'h01);
    sig_bytes(15);
    drive(1, 1, 8'h00, 1, 2'd0, 4'd0, "R8 stays unlocked");

    // Relock with nonzero follower.
    sync_pair(8'hFF);
    sig_bytes(14);
    drive(1, 1, 8'h33, 0, 2'd1, 4'd0, "R6 relock nonzero arms");
    drive(1, 1, 8'h00, 0, 2'd2, 4'd0, "R6 follower started sync");
    sig_bytes(15);

    // Relock with zero follower.
    sync_pair(8'h80);
    sig_bytes(14);
    drive(1, 1, 8'h00, 0, 2'd0, 4'd0, "R6 relock zero hunts");

    // Relock while locked.
    sync_pair(8'h07);
    sig_bytes(14);
    drive(1, 1, 8'h01, 0, 2'd1, 4'd0, "R8 stays locked");

    // Mismatch paths, starting unlocked.
    drive(1, 1, 8'h00, 0, 2'd2, 4'd0, "R3 zero enters signature");
    sig_bytes(15);
    sync_pair(8'h55);
    sig_bytes(3);
    drive(1, 1, 8'h10, 1, 2'd1, 4'd0, "R7 nonzero mismatch arms");
    drive(1, 1, 8'h00, 1, 2'd2, 4'd0, "R7 mismatch byte was sync half");
    sig_bytes(2);
    drive(1, 1, 8'h00, 1, 2'd0, 4'd0, "R7 zero mismatch hunts");
    drive(1, 1, 8'hEE, 1, 2'd1, 4'd0, "R3 nonzero arms");
    drive(1, 1, 8'h00, 1, 2'd2, 4'd0, "R3 zero enters signature");
    drive(1, 1, 8'h77, 1, 2'd1, 4'd0, "R7 wrong first byte arms");

    @(negedge clk);
    wr_en = 1'b0; wr_sel = 1'b0;
    repeat (3) @(negedge clk);
    r.unl = 1; r.ph = 1; r.cnt = 0; r.req = "R2 idle hold";
    check_now(r);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule